// File: doc/BRIEF.md
# Multi-Mode Conversion Cycle Sequencer

This block paces the conversion handshake of a successive-approximation converter that offers three speed/power modes. Two mode pins pick the mode; the choice is latched when a start request is accepted. An accepted start raises the busy output on the next clock, busy is held for the conversion length of the latched mode, the externally supplied result is captured and flagged valid one cycle before busy drops, and then an acquisition window must pass before another start is taken.

Starts that land while busy is high, or inside the acquisition window, are dropped and leave a sticky overrun flag. In the fastest mode the converter loses accuracy if it sits too long between conversions, so a gap counter measures the cycles since the last accepted start and raises a stale flag once that limit is passed; the next completed conversion clears it. All timings are clock-cycle counts set by parameters.

Top module: `cvt_seq_top`

## Requirements
- R1: Mode decode: fast_pin high with lowp_pin low selects fast mode, lowp_pin high with fast_pin low selects low-power mode, any other pin pair selects normal mode. The mode is latched at an accepted start and shown on mode_o as 2'b01 fast, 2'b10 low-power, 2'b00 normal.
- R2: A start_i seen in a cycle while the block is idle is accepted; busy_o rises in the next cycle and stays high for exactly CONV_FAST, CONV_NORM or CONV_LOWP cycles for the latched mode.
- R3: After busy_o falls, start_i is ignored during the first ACQ_CYC-1 busy-low cycles; a start in busy-low cycle ACQ_CYC or later is accepted, so the shortest start-to-start spacing is the conversion length plus ACQ_CYC.
- R4: valid_o is low in the first busy cycle of every conversion and rises in the last busy cycle, one cycle before busy_o falls.
- R5: data_o takes the value of result_i present in the second-to-last busy cycle and holds it, with valid_o high, until the next accepted start.
- R6: A start_i while busy_o is high or during the acquisition window has no effect on busy_o, valid_o or data_o and sets overrun_o, which stays high until reset.
- R7: With fast mode latched, if no start is accepted by the cycle MAX_GAP cycles after the previous accepted start, stale_o rises in the following cycle; a start in exactly that cycle is accepted and stale_o stays low.
- R8: stale_o clears in the cycle busy_o falls at the end of a conversion.
- R9: stale_o never rises while normal or low-power mode is latched, whatever the mode pins do meanwhile.
- R10: rst_n low clears busy_o, valid_o, overrun_o, stale_o, mode_o and data_o at once, without a clock; release takes effect after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start request, sampled each cycle |
| fast_pin | input | 1 | Mode select pin for the fast mode |
| lowp_pin | input | 1 | Mode select pin for the low-power mode |
| result_i | input | DATA_W | Conversion result from the converter core |
| busy_o | output | 1 | High while a conversion is running |
| valid_o | output | 1 | data_o holds the result of the last conversion |
| data_o | output | DATA_W | Captured conversion result |
| overrun_o | output | 1 | Sticky: a start request was dropped |
| stale_o | output | 1 | Fast mode gap limit exceeded |
| mode_o | output | 2 | Latched mode of the current or last conversion |

## Verification
The stale detector and the start acceptance can both act on the cycle the gap counter reaches MAX_GAP. The bench provokes this by issuing a fast-mode start and then placing the next start exactly MAX_GAP cycles later, and judges it by busy_o rising with stale_o still low; the same setup with the start withheld one cycle longer must show stale_o high, and a later conversion must drop stale_o together with busy_o. A sweep over every pin pair and every start offset across the acquisition window checks acceptance against overrun arithmetically.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_FAST = 2'b01,
    MODE_LOWP = 2'b10
  } cvt_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CONV = 2'b01,
    ST_ACQ  = 2'b10
  } cvt_state_e;

endpackage

// File: rtl/cvt_mode_dec.sv
module cvt_mode_dec
  import cvt_seq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int CONV_FAST = 6,
  parameter int CONV_NORM = 8,
  parameter int CONV_LOWP = 10
) (
  input  logic             fast_pin,
  input  logic             lowp_pin,
  output cvt_mode_e        mode_sel,
  output logic [CNT_W-1:0] conv_len
);

  always_comb begin
    unique case ({lowp_pin, fast_pin})
      2'b01:   mode_sel = MODE_FAST;
      2'b10:   mode_sel = MODE_LOWP;
      default: mode_sel = MODE_NORM;
    endcase
  end

  always_comb begin
    unique case (mode_sel)
      MODE_FAST: conv_len = CNT_W'(CONV_FAST);
      MODE_LOWP: conv_len = CNT_W'(CONV_LOWP);
      default:   conv_len = CNT_W'(CONV_NORM);
    endcase
  end

endmodule

// File: rtl/cvt_cycle_fsm.sv
module cvt_cycle_fsm
  import cvt_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 4,
  parameter int ACQ_CYC   = 3,
  parameter int CONV_FAST = 6,
  parameter int CONV_NORM = 8,
  parameter int CONV_LOWP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  cvt_mode_e         mode_sel,
  input  logic [CNT_W-1:0]  conv_len,
  input  logic [DATA_W-1:0] result_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              overrun_o,
  output cvt_mode_e         mode_o,
  output logic              start_acc_o,
  output logic              done_o
);

  cvt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              valid_q, valid_d, valid_en;
  logic [DATA_W-1:0] data_q;
  logic              ovr_q;
  cvt_mode_e         mode_q;
  logic              start_acc, start_rej, cap;

  assign start_acc = (state_q == ST_IDLE) && start_i;
  assign start_rej = (state_q != ST_IDLE) && start_i;
  assign cap       = (state_q == ST_CONV) && (cnt_q == CNT_W'(1));
  assign done_o    = (state_q == ST_CONV) && (cnt_q == '0);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_acc) begin
          state_d = ST_CONV;
          cnt_d   = conv_len - CNT_W'(1);
        end
      end
      ST_CONV: begin
        if (cnt_q == '0) begin
          state_d = ST_ACQ;
          cnt_d   = CNT_W'(ACQ_CYC - 2);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_ACQ: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign valid_en = start_acc || cap;
  assign valid_d  = cap;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid_q <= 1'b0;
    else if (valid_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (cap) data_q <= result_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (start_rej) ovr_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= MODE_NORM;
    else if (start_acc) mode_q <= mode_sel;
  end

  assign busy_o      = (state_q == ST_CONV);
  assign valid_o     = valid_q;
  assign data_o      = data_q;
  assign overrun_o   = ovr_q;
  assign mode_o      = mode_q;
  assign start_acc_o = start_acc;

  // checker-only busy length counter
  logic [CNT_W-1:0] chk_len_q;
  logic [CNT_W-1:0] chk_exp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chk_len_q <= '0;
    else if (start_acc) chk_len_q <= '0;
    else if (busy_o)    chk_len_q <= chk_len_q + CNT_W'(1);
  end
  always_comb begin
    unique case (mode_q)
      MODE_FAST: chk_exp = CNT_W'(CONV_FAST - 1);
      MODE_LOWP: chk_exp = CNT_W'(CONV_LOWP - 1);
      default:   chk_exp = CNT_W'(CONV_NORM - 1);
    endcase
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy_o); // R2
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chk_len_q == chk_exp)); // R2
  AST_REJECT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rej && !done_o) |=> (busy_o == $past(busy_o))); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |=> ovr_q); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !busy_o) |=> $stable(data_q)); // R5
  AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_q)); // R1

endmodule

// File: rtl/cvt_stale_mon.sv
module cvt_stale_mon
  import cvt_seq_pkg::*;
#(
  parameter int MAX_GAP = 40,
  parameter int GAP_W   = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_acc,
  input  logic      done,
  input  cvt_mode_e mode_q,
  output logic      stale_o
);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_en;
  logic             stale_q, stale_d, stale_en, stale_set;

  assign gap_en    = start_acc || (gap_q != GAP_W'(MAX_GAP));
  assign gap_d     = start_acc ? GAP_W'(1) : gap_q + GAP_W'(1);
  assign stale_set = (gap_q == GAP_W'(MAX_GAP)) && !start_acc && (mode_q == MODE_FAST);
  assign stale_en  = stale_set || done;
  assign stale_d   = stale_set && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stale_q <= 1'b0;
    else if (stale_en) stale_q <= stale_d;
  end

  assign stale_o = stale_q;

  AST_STALE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !stale_q); // R8
  AST_STALE_FAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale_q) |-> (mode_q == MODE_FAST)); // R9
  AST_STALE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale_q) |-> $past(!start_acc)); // R7

endmodule

// File: rtl/cvt_seq_top.sv
module cvt_seq_top
  import cvt_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CONV_FAST = 6,
  parameter int CONV_NORM = 8,
  parameter int CONV_LOWP = 10,
  parameter int ACQ_CYC   = 3,
  parameter int MAX_GAP   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fast_pin,
  input  logic              lowp_pin,
  input  logic [DATA_W-1:0] result_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              overrun_o,
  output logic              stale_o,
  output logic [1:0]        mode_o
);

  localparam int CONV_MAX = (CONV_FAST > CONV_NORM) ?
                            ((CONV_FAST > CONV_LOWP) ? CONV_FAST : CONV_LOWP) :
                            ((CONV_NORM > CONV_LOWP) ? CONV_NORM : CONV_LOWP);
  localparam int CNT_MAX  = (CONV_MAX > ACQ_CYC) ? CONV_MAX : ACQ_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int GAP_W    = $clog2(MAX_GAP + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cvt_mode_e        mode_sel, mode_q;
  logic [CNT_W-1:0] conv_len;
  logic             start_acc, done;

  cvt_mode_dec #(
    .CNT_W(CNT_W), .CONV_FAST(CONV_FAST), .CONV_NORM(CONV_NORM), .CONV_LOWP(CONV_LOWP)
  ) u_dec (
    .fast_pin(fast_pin), .lowp_pin(lowp_pin), .mode_sel(mode_sel), .conv_len(conv_len)
  );

  cvt_cycle_fsm #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ACQ_CYC(ACQ_CYC),
    .CONV_FAST(CONV_FAST), .CONV_NORM(CONV_NORM), .CONV_LOWP(CONV_LOWP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sync_q), .start_i(start_i), .mode_sel(mode_sel),
    .conv_len(conv_len), .result_i(result_i), .busy_o(busy_o), .valid_o(valid_o),
    .data_o(data_o), .overrun_o(overrun_o), .mode_o(mode_q),
    .start_acc_o(start_acc), .done_o(done)
  );

  cvt_stale_mon #(
    .MAX_GAP(MAX_GAP), .GAP_W(GAP_W)
  ) u_stale (
    .clk(clk), .rst_n(rst_sync_q), .start_acc(start_acc), .done(done),
    .mode_q(mode_q), .stale_o(stale_o)
  );

  assign mode_o = mode_q;

  AST_VALID_LEADS_FALL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(busy_o) |-> $past(valid_o)); // R4
  AST_VALID_LOW_AT_RISE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(busy_o) |-> !valid_o); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    overrun_o |=> overrun_o); // R6
  AST_STALE_FALLS_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(stale_o) |-> $fell(busy_o)); // R8

endmodule

// File: tb/sim_cvt_seq_top.sv
`timescale 1ns/1ps
module sim_cvt_seq_top;

  localparam int DW   = 16;
  localparam int CF   = 6;
  localparam int CN   = 8;
  localparam int CL   = 10;
  localparam int ACQ  = 3;
  localparam int GAP  = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, fast_pin, lowp_pin;
  logic [DW-1:0] result_i;
  logic busy_o, valid_o, overrun_o, stale_o;
  logic [DW-1:0] data_o;
  logic [1:0] mode_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cvt_seq_top #(.DATA_W(DW), .CONV_FAST(CF), .CONV_NORM(CN), .CONV_LOWP(CL),
                .ACQ_CYC(ACQ), .MAX_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_pin(fast_pin),
    .lowp_pin(lowp_pin), .result_i(result_i), .busy_o(busy_o), .valid_o(valid_o),
    .data_o(data_o), .overrun_o(overrun_o), .stale_o(stale_o), .mode_o(mode_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic f, input logic l);
    if (f && !l) return CF;
    if (l && !f) return CL;
    return CN;
  endfunction

  function automatic logic [1:0] exp_mode(input logic f, input logic l);
    if (f && !l) return 2'b01;
    if (l && !f) return 2'b10;
    return 2'b00;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // start at this negedge, run to the first busy-low negedge
  task automatic do_conv(input logic f, input logic l, input logic [DW-1:0] d);
    int blen;
    logic first_valid, last_valid;
    fast_pin = f; lowp_pin = l; result_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    blen = 0; first_valid = 1'b1; last_valid = 1'b0;
    while (busy_o && blen < 64) begin
      if (blen == 0) first_valid = valid_o;
      last_valid = valid_o;
      blen++;
      @(negedge clk);
    end
    chk(blen == exp_len(f, l), "R2 busy length", blen, exp_len(f, l));
    chk(first_valid == 1'b0, "R4 valid low at busy start", first_valid, 0);
    chk(last_valid == 1'b1, "R4 valid in last busy cycle", last_valid, 1);
    chk(data_o == d, "R5 captured data", data_o, d);
    chk(mode_o == exp_mode(f, l), "R1 latched mode", mode_o, exp_mode(f, l));
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; fast_pin = 1'b0; lowp_pin = 1'b0; result_i = '0;
    repeat (2) @(negedge clk);
    chk(busy_o == 0 && valid_o == 0 && overrun_o == 0 && stale_o == 0 &&
        mode_o == 0 && data_o == 0, "R10 reset state",
        {busy_o, valid_o, overrun_o, stale_o, mode_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep: every pin pair, every restart offset over the acquisition window
    for (int m = 0; m < 4; m++) begin
      for (int off = 0; off <= ACQ + 1; off++) begin
        logic [DW-1:0] d;
        bit acc;
        d = DW'(16'hA5C3 ^ (m * 16'h1357) ^ (off * 16'h0F21));
        do_reset();
        do_conv(m[0], m[1], d);
        repeat (off) @(negedge clk);
        result_i = ~d;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        acc = (off >= ACQ - 1);
        chk(busy_o == acc, "R3 restart acceptance", busy_o, acc);
        chk(overrun_o == !acc, "R6 overrun on dropped start", overrun_o, !acc);
        if (acc) begin
          chk(valid_o == 1'b0, "R4 valid cleared by new start", valid_o, 0);
          while (busy_o) @(negedge clk);
          chk(data_o == ~d, "R5 second result", data_o, ~d);
        end else begin
          chk(valid_o == 1'b1 && data_o == d, "R6 dropped start leaves result",
              data_o, d);
        end
      end
    end

    // start while busy
    do_reset();
    fast_pin = 1'b0; lowp_pin = 1'b1; result_i = 16'h1234; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1 && overrun_o == 1, "R6 start during busy",
        {busy_o, overrun_o}, 2'b11);
    while (busy_o) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(overrun_o == 1, "R6 overrun sticky", overrun_o, 1);

    // stale flag raised when gap exceeded
    do_reset();
    fast_pin = 1'b1; lowp_pin = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (GAP - 1) @(negedge clk);
    chk(stale_o == 0, "R7 no stale at limit", stale_o, 0);
    @(negedge clk);
    chk(stale_o == 1, "R7 stale after limit", stale_o, 1);
    do_conv(1'b1, 1'b0, 16'hBEEF);
    chk(stale_o == 0, "R8 stale cleared by completion", stale_o, 0);

    // start exactly at the limit cycle
    do_reset();
    fast_pin = 1'b1; lowp_pin = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (GAP - 1) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1 && stale_o == 0, "R7 start at limit accepted",
        {busy_o, stale_o}, 2'b10);

    // non-fast modes never go stale, even with fast pins afterwards
    for (int m = 0; m < 2; m++) begin
      do_reset();
      fast_pin = 1'b0; lowp_pin = m[0]; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      fast_pin = 1'b1; lowp_pin = 1'b0;
      repeat (GAP + 8) @(negedge clk);
      chk(stale_o == 0, "R9 no stale outside fast mode", stale_o, 0);
    end

    // asynchronous reset in the middle of a conversion
    do_reset();
    fast_pin = 1'b0; lowp_pin = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk(busy_o == 0 && valid_o == 0, "R10 async clear", {busy_o, valid_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 0, "R10 start ignored during release", busy_o, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule